// File: doc/BRIEF.md
# Four-Mode Timer/Counter

This block is a timer/counter made from two 8-bit count registers, a low byte and a high byte. A two-bit mode input sets how the two bytes work together. They can form one 16-bit counter. The low byte's bottom bits can act as a prescaler in front of an 8-bit high counter. The low byte can count and reload itself from the high byte, which is how a baud-rate generator is usually built. Or the two bytes can run as two independent 8-bit counters.

Counting is driven by count events. In timer operation, a count event is a machine-cycle tick that arrives once every 12 system clocks. In counter operation, a count event is a rising edge on an external pin. The pin is synchronised and compared between successive ticks. Software writes either byte through a small write port and reads both bytes back directly. A sticky overflow flag raises an interrupt request when the interrupt is enabled. A one-clock rollover pulse goes to the serial bit-rate logic.

Top module: `quad_mode_timer`

## Requirements
- R1: After reset, both count bytes are 0x00, both overflow flags are 0, and `irq_o` and `rollover_o` are 0.
- R2: When `cnt_src_i`=0 and `run_i`=1, each clock with `tick_i` high is one count event for the main counter.
- R3: When `cnt_src_i`=1 and `run_i`=1, a count event happens on a `tick_i` clock when the two-flop-synchronised `ext_evt_i` reads 1 and the value captured at the previous tick was 0.
- R4: While `run_i`=0, the main counter takes no count events, whatever `tick_i` and `ext_evt_i` do.
- R5: When `mode_i`=0, {hi,lo} is one 16-bit counter. A count event at 0xFFFF gives 0x0000 and sets the main overflow flag.
- R6: When `mode_i`=1, lo[4:0] is a 32-step prescaler and lo[7:5] hold their value. The high byte advances when lo[4:0] wraps from 31 to 0, and the main flag is set when the high byte wraps from 255 to 0.
- R7: When `mode_i`=2, the low byte counts. A count event at 0xFF loads the value of the high byte into the low byte and sets the main flag. The high byte is not changed by counting.
- R8: When `mode_i`=3, the low byte is an 8-bit counter that sets the main flag when it wraps. The high byte counts every `tick_i` while `run_hi_i`=1, whatever the values of `cnt_src_i` and `run_i`, and sets the second flag `hi_ovf_o` when it wraps.
- R9: Both flags stay set until `ovf_clr_i` is high. If a flag is cleared and set in the same clock, the set wins.
- R10: `irq_o` equals `irq_en_i` AND (`ovf_o` OR `hi_ovf_o`).
- R11: When `wr_en_i`=1, `wr_data_i` goes into the low byte (`wr_sel_i`=0) or the high byte (`wr_sel_i`=1). No count event takes effect in that clock.
- R12: `rollover_o` is high for exactly the one clock after each edge that sets the main flag through counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle tick, one clock in every 12 |
| ext_evt_i | input | 1 | External event pin, asynchronous |
| cnt_src_i | input | 1 | 0 = count ticks, 1 = count external edges |
| mode_i | input | 2 | 0 wide16, 1 prescaled, 2 reload, 3 split |
| run_i | input | 1 | Main counter enable |
| run_hi_i | input | 1 | High-byte enable in split mode |
| irq_en_i | input | 1 | Interrupt enable |
| ovf_clr_i | input | 1 | Clears both overflow flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = low byte, 1 = high byte |
| wr_data_i | input | 8 | Write data |
| cnt_lo_o | output | 8 | Low count byte |
| cnt_hi_o | output | 8 | High count byte |
| ovf_o | output | 1 | Sticky main overflow flag |
| hi_ovf_o | output | 1 | Sticky split-mode high-byte flag |
| irq_o | output | 1 | Interrupt request |
| rollover_o | output | 1 | One-clock main rollover pulse |

## Verification
The bench forces the carry across the full 16-bit boundary at 0xFFFF. A design with a broken carry chain would wrap the low byte and leave the high byte as it was, or miss the flag. It starts the prescaler with lo[7:5] non-zero, so a design that counts through all eight bits would corrupt those bits or advance the high byte too late. It runs reload mode with the low byte close to 0xFF, so a design that reloads zero, or reloads one count late, shows a wrong low byte. It drives random writes that fall on tick clocks, so a design that lets the increment win would show a byte one above the written value. It toggles the external pin slowly, so a design that counts on the level instead of on the edge would count far too many events.

// File: rtl/quad_mode_timer_pkg.sv
package quad_mode_timer_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TM_WIDE   = 2'd0,
        TM_PRESC  = 2'd1,
        TM_RELOAD = 2'd2,
        TM_SPLIT  = 2'd3
    } tm_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              ovf;
        logic              hi_ovf;
        logic              roll;
    } tm_core_t;
endpackage

// File: rtl/tm_event_gen.sv
module tm_event_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ext_evt_i,
    input  logic cnt_src_i,
    input  logic run_i,
    input  logic run_hi_i,
    output logic cnt_en_o,
    output logic hi_en_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } evt_t;

    evt_t st_d, st_q;
    logic edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ext_evt_i};
        if (tick_i) st_d.prev = st_q.sync[SYNC_STAGES-1];
        edge_seen = tick_i & st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
        cnt_en_o  = run_i & (cnt_src_i ? edge_seen : tick_i);
        hi_en_o   = run_hi_i & tick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    edge_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_src_i && cnt_en_o) |-> tick_i);
endmodule

// File: rtl/tm_count_core.sv
module tm_count_core
    import quad_mode_timer_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tm_mode_e          mode_i,
    input  logic              cnt_en_i,
    input  logic              hi_en_i,
    input  logic              ovf_clr_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output tm_core_t          st_o
);
    localparam logic [BYTE_W-1:0]   BYTE_MAX = {BYTE_W{1'b1}};
    localparam logic [2*BYTE_W-1:0] WIDE_MAX = {2*BYTE_W{1'b1}};

    tm_core_t st_d, st_q;
    logic inc, hinc;
    logic [2*BYTE_W:0]   wide_sum;
    logic [PRE_W:0]      pre_sum;
    logic [BYTE_W:0]     lo_sum, hi_sum;

    always_comb begin
        st_d      = st_q;
        st_d.roll = 1'b0;
        inc       = cnt_en_i & ~wr_en_i;
        hinc      = hi_en_i & ~wr_en_i & (mode_i == TM_SPLIT);
        wide_sum  = {1'b0, st_q.hi, st_q.lo} + 1'b1;
        pre_sum   = {1'b0, st_q.lo[PRE_W-1:0]} + 1'b1;
        lo_sum    = {1'b0, st_q.lo} + 1'b1;
        hi_sum    = {1'b0, st_q.hi} + 1'b1;

        if (ovf_clr_i) begin
            st_d.ovf    = 1'b0;
            st_d.hi_ovf = 1'b0;
        end

        if (inc) begin
            unique case (mode_i)
                TM_WIDE: begin
                    {st_d.hi, st_d.lo} = wide_sum[2*BYTE_W-1:0];
                    if (wide_sum[2*BYTE_W]) begin
                        st_d.ovf  = 1'b1;
                        st_d.roll = 1'b1;
                    end
                end
                TM_PRESC: begin
                    st_d.lo[PRE_W-1:0] = pre_sum[PRE_W-1:0];
                    if (pre_sum[PRE_W]) begin
                        st_d.hi = hi_sum[BYTE_W-1:0];
                        if (hi_sum[BYTE_W]) begin
                            st_d.ovf  = 1'b1;
                            st_d.roll = 1'b1;
                        end
                    end
                end
                TM_RELOAD: begin
                    if (st_q.lo == BYTE_MAX) begin
                        st_d.lo   = st_q.hi;
                        st_d.ovf  = 1'b1;
                        st_d.roll = 1'b1;
                    end else begin
                        st_d.lo = lo_sum[BYTE_W-1:0];
                    end
                end
                default: begin
                    st_d.lo = lo_sum[BYTE_W-1:0];
                    if (lo_sum[BYTE_W]) begin
                        st_d.ovf  = 1'b1;
                        st_d.roll = 1'b1;
                    end
                end
            endcase
        end

        if (hinc) begin
            st_d.hi = hi_sum[BYTE_W-1:0];
            if (hi_sum[BYTE_W]) st_d.hi_ovf = 1'b1;
        end

        if (wr_en_i) begin
            if (wr_sel_i) st_d.hi = wr_data_i;
            else          st_d.lo = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    // R5
    wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_WIDE && cnt_en_i && !wr_en_i && {st_q.hi, st_q.lo} == WIDE_MAX)
        |=> ({st_q.hi, st_q.lo} == '0 && st_q.ovf));

    // R7
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_RELOAD && cnt_en_i && !wr_en_i && st_q.lo == BYTE_MAX)
        |=> (st_q.lo == $past(st_q.hi)));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (st_q.lo == $past(wr_data_i)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr_i) |=> st_q.ovf);

    // R12
    roll_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.roll |-> st_q.ovf);
endmodule

// File: rtl/quad_mode_timer.sv
module quad_mode_timer
    import quad_mode_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        ext_evt_i,
    input  logic        cnt_src_i,
    input  logic [1:0]  mode_i,
    input  logic        run_i,
    input  logic        run_hi_i,
    input  logic        irq_en_i,
    input  logic        ovf_clr_i,
    input  logic        wr_en_i,
    input  logic        wr_sel_i,
    input  logic [7:0]  wr_data_i,
    output logic [7:0]  cnt_lo_o,
    output logic [7:0]  cnt_hi_o,
    output logic        ovf_o,
    output logic        hi_ovf_o,
    output logic        irq_o,
    output logic        rollover_o
);
    logic     cnt_en, hi_en;
    tm_core_t core_st;
    tm_mode_e mode;

    assign mode = tm_mode_e'(mode_i);

    tm_event_gen #(.SYNC_STAGES(SYNC_STAGES)) evt_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_evt_i(ext_evt_i),
        .cnt_src_i(cnt_src_i), .run_i(run_i), .run_hi_i(run_hi_i),
        .cnt_en_o(cnt_en), .hi_en_o(hi_en)
    );

    tm_count_core #(.PRE_W(PRE_W)) core_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cnt_en_i(cnt_en),
        .hi_en_i(hi_en), .ovf_clr_i(ovf_clr_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .st_o(core_st)
    );

    assign cnt_lo_o   = core_st.lo;
    assign cnt_hi_o   = core_st.hi;
    assign ovf_o      = core_st.ovf;
    assign hi_ovf_o   = core_st.hi_ovf;
    assign rollover_o = core_st.roll;
    assign irq_o      = irq_en_i & (core_st.ovf | core_st.hi_ovf);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !run_hi_i && !wr_en_i) |=> $stable({cnt_hi_o, cnt_lo_o}));
endmodule

// File: tb/quad_mode_timer_tb.sv
`timescale 1ns/1ps
module quad_mode_timer_tb_top;
    logic clk = 0, rst_n = 0;
    logic tick_i = 0, ext_evt_i = 0, cnt_src_i = 0, run_i = 0, run_hi_i = 0;
    logic irq_en_i = 0, ovf_clr_i = 0, wr_en_i = 0, wr_sel_i = 0;
    logic [1:0] mode_i = 0;
    logic [7:0] wr_data_i = 0;
    logic [7:0] cnt_lo_o, cnt_hi_o;
    logic ovf_o, hi_ovf_o, irq_o, rollover_o;

    always #10 clk = ~clk;

    quad_mode_timer dut_i (.*);

    int checks = 0, errors = 0, phase = 0;
    bit done = 0;
    string tag = "R1";

    // bench reference state
    logic [7:0] m_lo = 0, m_hi = 0;
    logic m_ovf = 0, m_hovf = 0, m_roll = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;

    task automatic check(string rq, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    // reference update for one clock, from the inputs held in that clock
    task automatic model_step();
        logic ev, edg, hev;
        logic [16:0] w;
        logic [8:0] s;
        logic [5:0] p;
        edg = tick_i & m_s2 & ~m_prev;
        ev  = run_i & (cnt_src_i ? edg : tick_i) & ~wr_en_i;
        hev = run_hi_i & tick_i & ~wr_en_i & (mode_i == 2'd3);
        if (tick_i) m_prev = m_s2;
        m_s2 = m_s1; m_s1 = ext_evt_i;
        m_roll = 0;
        if (ovf_clr_i) begin m_ovf = 0; m_hovf = 0; end
        if (ev) begin
            case (mode_i)
                2'd0: begin
                    w = {1'b0, m_hi, m_lo} + 17'd1;
                    {m_hi, m_lo} = w[15:0];
                    if (w[16]) begin m_ovf = 1; m_roll = 1; end
                end
                2'd1: begin
                    p = {1'b0, m_lo[4:0]} + 6'd1;
                    m_lo[4:0] = p[4:0];
                    if (p[5]) begin
                        s = {1'b0, m_hi} + 9'd1; m_hi = s[7:0];
                        if (s[8]) begin m_ovf = 1; m_roll = 1; end
                    end
                end
                2'd2: begin
                    if (m_lo == 8'hFF) begin m_lo = m_hi; m_ovf = 1; m_roll = 1; end
                    else m_lo = m_lo + 8'd1;
                end
                default: begin
                    s = {1'b0, m_lo} + 9'd1; m_lo = s[7:0];
                    if (s[8]) begin m_ovf = 1; m_roll = 1; end
                end
            endcase
        end
        if (hev) begin
            s = {1'b0, m_hi} + 9'd1; m_hi = s[7:0];
            if (s[8]) m_hovf = 1;
        end
        if (wr_en_i) begin
            if (wr_sel_i) m_hi = wr_data_i; else m_lo = wr_data_i;
        end
    endtask

    task automatic compare_all();
        check(tag, "lo", cnt_lo_o, m_lo);
        check(tag, "hi", cnt_hi_o, m_hi);
        check("R9", "ovf", ovf_o, m_ovf);
        check("R9", "hi_ovf", hi_ovf_o, m_hovf);
        check("R10", "irq", irq_o, irq_en_i & (m_ovf | m_hovf));
        check("R12", "rollover", rollover_o, m_roll);
    endtask

    // inputs are already driven; tick is generated here
    task automatic cycle();
        tick_i = (phase == 11);
        phase = (phase + 1) % 12;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_en_i = 0; ovf_clr_i = 0;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
        cycle();
    endtask

    task automatic run_n(int n, int ext_pct, int wr_pct, int clr_pct, bit rnd_hi);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(99) < ext_pct) ext_evt_i = ~ext_evt_i;
            if ($urandom_range(99) < wr_pct) begin
                wr_en_i = 1; wr_sel_i = $urandom_range(1); wr_data_i = $urandom_range(255);
            end
            if ($urandom_range(99) < clr_pct) ovf_clr_i = 1;
            if (rnd_hi && $urandom_range(99) < 2) run_hi_i = ~run_hi_i;
            cycle();
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "lo", cnt_lo_o, 0); check("R1", "hi", cnt_hi_o, 0);
        check("R1", "ovf", ovf_o, 0); check("R1", "hi_ovf", hi_ovf_o, 0);
        check("R1", "irq", irq_o, 0); check("R1", "rollover", rollover_o, 0);
        rst_n = 1;
        @(negedge clk);
        irq_en_i = 1;
        // R2: timer source, wide mode
        tag = "R2"; run_i = 1; cnt_src_i = 0; mode_i = 0;
        run_n(240, 0, 0, 0, 0);
        check("R2", "lo after 20 ticks", cnt_lo_o, 20);
        // R3: external edges
        tag = "R3"; cnt_src_i = 1;
        run_n(3000, 3, 0, 0, 0);
        // R4: stopped
        tag = "R4"; run_i = 0;
        wr(0, 8'h33);
        run_n(600, 5, 0, 0, 0);
        check("R4", "lo held", cnt_lo_o, 8'h33);
        // R5: 16-bit wrap
        tag = "R5"; run_i = 1; cnt_src_i = 0; ovf_clr_i = 1;
        wr(1, 8'hFF); wr(0, 8'hF8);
        run_n(240, 0, 0, 0, 0);
        check("R5", "flag after wrap", ovf_o, 1);
        // R6: prescaler with lo[7:5] non-zero
        tag = "R6"; mode_i = 1; ovf_clr_i = 1;
        wr(0, 8'hE3); wr(1, 8'hFE);
        run_n(12 * 80, 0, 0, 0, 0);
        check("R6", "upper lo bits held", cnt_lo_o[7:5], 3'b111);
        check("R6", "flag after hi wrap", ovf_o, 1);
        // R7: reload
        tag = "R7"; mode_i = 2; ovf_clr_i = 1;
        wr(1, 8'hF0); wr(0, 8'hFA);
        run_n(12 * 40, 0, 0, 0, 0);
        check("R7", "hi unchanged", cnt_hi_o, 8'hF0);
        // R8: split
        tag = "R8"; mode_i = 3; run_hi_i = 1; ovf_clr_i = 1;
        wr(1, 8'hF8); wr(0, 8'hF0);
        run_n(12 * 300, 2, 0, 1, 1);
        run_i = 0; run_hi_i = 1; cnt_src_i = 1;
        run_n(12 * 20, 0, 0, 0, 0);
        // R9: clear while set
        tag = "R9"; ovf_clr_i = 1; cycle();
        check("R9", "cleared", ovf_o, 0);
        irq_en_i = 0; cycle();
        check("R10", "irq masked", irq_o, 0);
        // R11: random mix with writes landing on ticks
        tag = "R11"; irq_en_i = 1; run_i = 1;
        for (int k = 0; k < 8; k++) begin
            mode_i = $urandom_range(3);
            cnt_src_i = $urandom_range(1);
            run_n(2000, 4, 10, 2, 1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule